// File: doc/BRIEF.md
# Three-level nested interrupt arbiter

This block sits between a set of interrupt sources and a CPU core. Twelve request lines come in, each with its own enable. They are folded onto ten vectors, and several sources may share a vector. Each vector carries a one-bit level select. The block compares the pending vectors with the level of the handler now running. When a request qualifies, it raises a one-clock accept pulse. With the pulse it gives the vector address to fetch and the new running level.

Level codes on `active_lvl` are 0 = idle (below low), 1 = low, 2 = high and 3 = top. A vector is accepted only if its level is strictly above the running level. Among the pending vectors, the highest level wins, and a tie goes to the lowest vector index. On each acceptance the level that was running is pushed onto a three-entry stack. A return strobe pops that level back.

The control is a three-state machine:
- `ST_READY`: arbitration is armed. The transition *take* goes to `ST_ACCEPT`. It fires when the best pending level is above the running level, no return strobe is present and the stack has room.
- `ST_ACCEPT`: the accept pulse is driven. The unconditional transition *issue* goes to `ST_WAIT`.
- `ST_WAIT`: arbitration is held off. The transition *release* goes back to `ST_READY` on `cpu_ready`.

Top module: `irq_nest_arb`

## Requirements
- R1: After reset, `accept` is 0, `active_lvl` is 0 and `vec_addr` is 0x0003.
- R2: A vector is pending when at least one source mapped to it has both its request and its enable bit at 1. A source whose enable is 0 has no effect on arbitration. The mapping is: source 0 to vector 0, source 1 to vector 1, sources 2/3/4 to vector 2, source 5 to vector 3, source 6 to vector 4, source 7 to vector 7, sources 8/9/10 to vector 8, and source 11 to vector 9. Vectors 5 and 6 have no source.
- R3: Level select bit v set to 0 gives vector v level low (1). Set to 1, it gives level top (3) for vectors 0 and 1, and level high (2) for vectors 2 to 9.
- R4: A pending vector is accepted only when its level is strictly greater than `active_lvl`. A vector at an equal or lower level stays waiting.
- R5: When several vectors are pending, the one with the highest level is chosen.
- R6: Among pending vectors at the chosen level, the one with the lowest index is chosen.
- R7: `vec_addr` equals 0x0003 + 8 × (chosen vector index), so it runs from 0x0003 to 0x004B.
- R8: `accept` is high for exactly one clock, in the second cycle after the request is presented. In that same cycle `active_lvl` already shows the accepted level.
- R9: After an accept, no further accept happens until `cpu_ready` has been seen high, even if a higher request is pending.
- R10: `reti` restores `active_lvl` to the level that was running before the most recent accept. With an empty stack, `reti` leaves `active_lvl` at 0. No accept is taken in a cycle where `reti` is high.
- R11: Nesting from idle through low, high and top uses at most three stack entries. Unwinding with three returns passes through levels 2, 1 and 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| src_req | input | 12 | Per-source request flags |
| src_en | input | 12 | Per-source enables |
| lvl_sel | input | 10 | Per-vector level select |
| cpu_ready | input | 1 | CPU is ready to take another interrupt |
| reti | input | 1 | Return-from-interrupt strobe |
| accept | output | 1 | One-clock accept pulse |
| vec_addr | output | 16 | Address of the accepted vector |
| active_lvl | output | 2 | Level now running (0 idle, 1 low, 2 high, 3 top) |

## Verification
The assertions assume `reti` arrives only while a handler is running, so a pop never meets an empty stack. They also assume the CPU leaves `cpu_ready` low until it has taken an accept. The bench returns only from levels it has itself accepted. It drops the request flags of a vector once that vector is accepted, and it pulses `cpu_ready` only after an accept. The one deliberate empty-stack return goes through the guarded path, which ignores it.

// File: rtl/irq_arb_pkg.sv
package irq_arb_pkg;

    localparam int LVL_W = 2;

    localparam logic [LVL_W-1:0] LVL_NONE = 2'd0;
    localparam logic [LVL_W-1:0] LVL_LOW  = 2'd1;
    localparam logic [LVL_W-1:0] LVL_HIGH = 2'd2;
    localparam logic [LVL_W-1:0] LVL_TOP  = 2'd3;

    typedef enum logic [1:0] {
        ST_READY  = 2'd0,
        ST_ACCEPT = 2'd1,
        ST_WAIT   = 2'd2
    } arb_state_e;

    // Source-to-vector routing; several sources may fold onto one vector.
    function automatic int src_vec(input int s);
        case (s)
            0:       return 0;
            1:       return 1;
            2, 3, 4: return 2;
            5:       return 3;
            6:       return 4;
            7:       return 7;
            8, 9, 10: return 8;
            11:      return 9;
            default: return s % 10;
        endcase
    endfunction

endpackage

// File: rtl/irq_src_gather.sv
module irq_src_gather
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC = 12,
    parameter int NUM_VEC = 10
) (
    input  logic [NUM_SRC-1:0] src_req,
    input  logic [NUM_SRC-1:0] src_en,
    output logic [NUM_VEC-1:0] pend
);

    always_comb begin
        pend = '0;
        for (int v = 0; v < NUM_VEC; v++) begin
            for (int s = 0; s < NUM_SRC; s++) begin
                if (src_vec(s) == v) begin
                    pend[v] = pend[v] | (src_req[s] & src_en[s]);
                end
            end
        end
    end

endmodule

// File: rtl/irq_vec_pick.sv
module irq_vec_pick
    import irq_arb_pkg::*;
#(
    parameter int NUM_VEC  = 10,
    parameter int TOP_VECS = 2,
    localparam int IDX_W   = $clog2(NUM_VEC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_VEC-1:0] pend,
    input  logic [NUM_VEC-1:0] lvl_sel,
    output logic               win_valid,
    output logic [IDX_W-1:0]   win_idx,
    output logic [LVL_W-1:0]   win_lvl
);

    logic [LVL_W-1:0] vlvl [NUM_VEC];

    for (genvar g = 0; g < NUM_VEC; g++) begin : g_lvl
        if (g < TOP_VECS) begin : g_top
            assign vlvl[g] = !pend[g] ? LVL_NONE : (lvl_sel[g] ? LVL_TOP : LVL_LOW);
        end else begin : g_high
            assign vlvl[g] = !pend[g] ? LVL_NONE : (lvl_sel[g] ? LVL_HIGH : LVL_LOW);
        end

        // No pending vector may outrank the chosen one.
        assert_no_better_R5: assert property (@(posedge clk) disable iff (!rst_n)
            !(vlvl[g] > win_lvl));
        // A same-level competitor must not sit at a lower index.
        assert_tie_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (win_valid && vlvl[g] == win_lvl) |-> (win_idx <= IDX_W'(g)));
    end

    // Scan from the top index down; ">=" lets a lower index take a tie.
    always_comb begin
        win_lvl = LVL_NONE;
        win_idx = '0;
        for (int v = NUM_VEC - 1; v >= 0; v--) begin
            if (vlvl[v] != LVL_NONE && vlvl[v] >= win_lvl) begin
                win_lvl = vlvl[v];
                win_idx = IDX_W'(v);
            end
        end
        win_valid = (win_lvl != LVL_NONE);
    end

    assert_win_pending_R2: assert property (@(posedge clk) disable iff (!rst_n)
        win_valid |-> pend[win_idx]);

endmodule

// File: rtl/irq_lvl_stack.sv
module irq_lvl_stack
    import irq_arb_pkg::*;
#(
    parameter int DEPTH   = 3,
    localparam int CNT_W  = $clog2(DEPTH + 1),
    localparam int IDX_W  = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic             pop,
    input  logic [LVL_W-1:0] din,
    output logic [LVL_W-1:0] top,
    output logic             empty,
    output logic             full
);

    logic [LVL_W-1:0] mem [DEPTH];
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] tidx;

    assign empty = (cnt_q == '0);
    assign full  = (cnt_q == CNT_W'(DEPTH));
    assign tidx  = cnt_q - 1'b1;
    assign top   = empty ? LVL_NONE : mem[tidx[IDX_W-1:0]];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int i = 0; i < DEPTH; i++) begin
                mem[i] <= LVL_NONE;
            end
        end else if (pop) begin
            cnt_q <= cnt_q - 1'b1;
        end else if (push) begin
            mem[cnt_q[IDX_W-1:0]] <= din;
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> !full);
    assert_no_underflow_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> !empty);
    assert_push_grows_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (push && !pop) |=> (cnt_q == $past(cnt_q) + 1'b1));

endmodule

// File: rtl/irq_nest_arb.sv
module irq_nest_arb
    import irq_arb_pkg::*;
#(
    parameter int NUM_SRC     = 12,
    parameter int NUM_VEC     = 10,
    parameter int TOP_VECS    = 2,
    parameter int STACK_DEPTH = 3,
    parameter int ADDR_W      = 16,
    parameter int VEC_BASE    = 3,
    parameter int VEC_STEP    = 8,
    localparam int IDX_W      = $clog2(NUM_VEC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [NUM_SRC-1:0]  src_req,
    input  logic [NUM_SRC-1:0]  src_en,
    input  logic [NUM_VEC-1:0]  lvl_sel,
    input  logic                cpu_ready,
    input  logic                reti,
    output logic                accept,
    output logic [ADDR_W-1:0]   vec_addr,
    output logic [LVL_W-1:0]    active_lvl
);

    arb_state_e       state_q, state_d;
    logic [NUM_VEC-1:0] pend;
    logic               win_valid;
    logic [IDX_W-1:0]   win_idx;
    logic [LVL_W-1:0]   win_lvl;
    logic [LVL_W-1:0]   stk_top;
    logic               stk_empty, stk_full;
    logic               take, pop;
    logic [LVL_W-1:0]   act_q;
    logic [IDX_W-1:0]   idx_q;

    irq_src_gather #(.NUM_SRC(NUM_SRC), .NUM_VEC(NUM_VEC)) gather_i (
        .src_req (src_req),
        .src_en  (src_en),
        .pend    (pend)
    );

    irq_vec_pick #(.NUM_VEC(NUM_VEC), .TOP_VECS(TOP_VECS)) pick_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .pend      (pend),
        .lvl_sel   (lvl_sel),
        .win_valid (win_valid),
        .win_idx   (win_idx),
        .win_lvl   (win_lvl)
    );

    irq_lvl_stack #(.DEPTH(STACK_DEPTH)) stack_i (
        .clk   (clk),
        .rst_n (rst_n),
        .push  (take),
        .pop   (pop),
        .din   (act_q),
        .top   (stk_top),
        .empty (stk_empty),
        .full  (stk_full)
    );

    assign pop  = reti && !stk_empty;
    assign take = (state_q == ST_READY) && !reti && win_valid
                  && (win_lvl > act_q) && !stk_full;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_READY;
            act_q   <= LVL_NONE;
            idx_q   <= '0;
        end else begin
            state_q <= state_d;
            if (take) begin
                act_q <= win_lvl;
                idx_q <= win_idx;
            end else if (pop) begin
                act_q <= stk_top;
            end
        end
    end

    // Next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_READY:  if (take) state_d = ST_ACCEPT;
            ST_ACCEPT: state_d = ST_WAIT;
            ST_WAIT:   if (cpu_ready) state_d = ST_READY;
            default:   state_d = ST_READY;
        endcase
    end

    // Outputs
    always_comb begin
        accept     = (state_q == ST_ACCEPT);
        active_lvl = act_q;
        vec_addr   = ADDR_W'(VEC_BASE) + ADDR_W'(idx_q) * ADDR_W'(VEC_STEP);
    end

    assert_accept_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> !accept);
    assert_accept_raises_R4: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (active_lvl > $past(active_lvl)));
    assert_ready_gate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !cpu_ready) |=> !accept);
    assert_reti_lowers_R10: assert property (@(posedge clk) disable iff (!rst_n)
        pop |=> (active_lvl < $past(active_lvl)));
    assert_vec_align_R7: assert property (@(posedge clk) disable iff (!rst_n)
        accept |-> (vec_addr[2:0] == 3'b011));

endmodule

// File: tb/irq_nest_arb_tb.sv
module irq_nest_arb_tb_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [11:0] src_req;
    logic [11:0] src_en;
    logic [9:0]  lvl_sel;
    logic        cpu_ready;
    logic        reti;
    logic        accept;
    logic [15:0] vec_addr;
    logic [1:0]  active_lvl;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    irq_nest_arb dut_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .src_req    (src_req),
        .src_en     (src_en),
        .lvl_sel    (lvl_sel),
        .cpu_ready  (cpu_ready),
        .reti       (reti),
        .accept     (accept),
        .vec_addr   (vec_addr),
        .active_lvl (active_lvl)
    );

    // {req[11:0], en[11:0], sel[9:0], idx[3:0], lvl[1:0]}
    localparam logic [39:0] TBL [10] = '{
        {12'h001, 12'hFFF, 10'h000, 4'd0, 2'd1},
        {12'h001, 12'hFFF, 10'h001, 4'd0, 2'd3},
        {12'h008, 12'hFFF, 10'h004, 4'd2, 2'd2},
        {12'h880, 12'hFFF, 10'h000, 4'd7, 2'd1},
        {12'h880, 12'hFFF, 10'h200, 4'd9, 2'd2},
        {12'h042, 12'hFFF, 10'h010, 4'd4, 2'd2},
        {12'h042, 12'hFFF, 10'h012, 4'd1, 2'd3},
        {12'h014, 12'hFFB, 10'h000, 4'd2, 2'd1},
        {12'h600, 12'hFFF, 10'h000, 4'd8, 2'd1},
        {12'h003, 12'hFFF, 10'h003, 4'd0, 2'd3}
    };

    function automatic logic [15:0] exp_addr(input int idx);
        return 16'h0003 + 16'(idx) * 16'd8;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wait_acc(input int maxc, output bit got);
        got = 1'b0;
        for (int i = 0; i < maxc; i++) begin
            @(negedge clk);
            if (accept) begin
                got = 1'b1;
                break;
            end
        end
    endtask

    task automatic no_acc(input int cyc, input string req);
        bit seen;
        seen = 1'b0;
        for (int i = 0; i < cyc; i++) begin
            @(negedge clk);
            if (accept) seen = 1'b1;
        end
        check(req, 32'(seen), 32'd0);
    endtask

    // Called at the negedge where accept is high.
    task automatic handshake();
        src_req = '0;
        @(negedge clk);
        check("R8 pulse width", 32'(accept), 32'd0);
        cpu_ready = 1'b1;
        @(negedge clk);
        cpu_ready = 1'b0;
    endtask

    task automatic do_reti();
        reti = 1'b1;
        @(negedge clk);
        reti = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        bit got;
        rst_n = 1'b0;
        src_req = '0;
        src_en = '0;
        lvl_sel = '0;
        cpu_ready = 1'b0;
        reti = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1 accept", 32'(accept), 32'd0);
        check("R1 active_lvl", 32'(active_lvl), 32'd0);
        check("R1 vec_addr", 32'(vec_addr), 32'h0003);

        // Table walk: one request pattern per entry, from idle and back.
        for (int t = 0; t < 10; t++) begin
            src_en  = TBL[t][27:16];
            lvl_sel = TBL[t][15:6];
            src_req = TBL[t][39:28];
            wait_acc(4, got);
            check("R5/R6 accept seen", 32'(got), 32'd1);
            check("R7 vec_addr", 32'(vec_addr), 32'(exp_addr(int'(TBL[t][5:2]))));
            check("R3 active_lvl", 32'(active_lvl), 32'(TBL[t][1:0]));
            handshake();
            do_reti();
            check("R10 back to idle", 32'(active_lvl), 32'd0);
        end

        // R2: a disabled source is ignored, then counts once enabled.
        src_en = 12'hFDF;
        lvl_sel = '0;
        src_req = 12'h020;
        no_acc(5, "R2 disabled source");
        check("R2 level stays idle", 32'(active_lvl), 32'd0);
        src_en = 12'hFFF;
        wait_acc(4, got);
        check("R2 enabled source", 32'(got), 32'd1);
        check("R2 vec_addr", 32'(vec_addr), 32'(exp_addr(3)));
        handshake();
        do_reti();

        // R9 and R11: nest low, high, top, with ready holding off the second accept.
        lvl_sel = 10'h006;
        src_req = 12'h001;
        wait_acc(4, got);
        check("R11 low accepted", 32'(active_lvl), 32'd1);
        src_req = 12'h008;
        no_acc(6, "R9 held until ready");
        cpu_ready = 1'b1;
        @(negedge clk);
        cpu_ready = 1'b0;
        wait_acc(3, got);
        check("R9 accept after ready", 32'(got), 32'd1);
        check("R11 high nested", 32'(active_lvl), 32'd2);
        check("R7 high vec", 32'(vec_addr), 32'(exp_addr(2)));
        handshake();
        src_req = 12'h002;
        wait_acc(4, got);
        check("R11 top nested", 32'(active_lvl), 32'd3);
        check("R7 top vec", 32'(vec_addr), 32'(exp_addr(1)));
        handshake();

        // R4: low requests wait below top, then below high, then at equal level.
        src_req = 12'h0C0;
        no_acc(5, "R4 lower waits");
        check("R4 level held", 32'(active_lvl), 32'd3);
        do_reti();
        check("R11 unwind to high", 32'(active_lvl), 32'd2);
        no_acc(3, "R4 lower than high waits");
        do_reti();
        check("R11 unwind to low", 32'(active_lvl), 32'd1);
        no_acc(4, "R4 equal level waits");
        do_reti();
        wait_acc(3, got);
        check("R4 accepted from idle", 32'(got), 32'd1);
        check("R6 tie lowest index", 32'(vec_addr), 32'(exp_addr(4)));
        check("R8 level on accept", 32'(active_lvl), 32'd1);
        handshake();
        do_reti();
        check("R10 idle again", 32'(active_lvl), 32'd0);

        // R10: return with an empty stack is ignored.
        do_reti();
        check("R10 empty reti", 32'(active_lvl), 32'd0);

        // R10: a request present while reti is high is not taken in that cycle.
        lvl_sel = '0;
        src_req = 12'h001;
        reti = 1'b1;
        @(negedge clk);
        @(negedge clk);
        check("R10 no accept during reti", 32'(accept), 32'd0);
        reti = 1'b0;
        wait_acc(3, got);
        check("R10 accept after reti", 32'(got), 32'd1);
        handshake();
        do_reti();

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule